// File: doc/BRIEF.md
# Display Memory Access Sequencer

This block runs every access to an external 64K x 8 display SRAM. It drives a 16-bit address, an 8-bit write data path with an output enable (the tristate pad sits outside the block), an active-low chip enable and a direction line. It takes the 8-bit read data back from the pad. Each memory cycle lasts exactly three controller clocks: one clock with the enable high, then two clocks with it low.

Two sources share the memory. The display pipeline issues refresh fetches with a valid/acknowledge handshake. These always win the next free slot. The host side places one read or one write into a single-entry buffer. The buffered access waits for a slot that refresh does not claim, so host traffic never delays a refresh fetch. Read data for each source comes back in its own return register, together with a one-clock valid pulse.

Top module: `vram_seq`

## Requirements
- R1: While reset is held and on the first clock after it, `mem_ce_n` is 1, `mem_rw` is 1, `mem_dq_oe` is 0, `host_busy` is 0, and both read-valid outputs are 0.
- R2: In every memory cycle `mem_ce_n` is high for exactly one clock and then low for exactly two clocks. Back-to-back cycles repeat every three clocks.
- R3: `mem_rw` is 1 for a read cycle and 0 for a write cycle. It does not change while `mem_ce_n` is low.
- R4: During a write cycle `mem_dq_oe` is 1 whenever `mem_ce_n` is low. `mem_dq_out` holds the host write byte, unchanged, through the low phase until the enable rises.
- R5: Read data is sampled from `mem_dq_in` on the last clock of the low phase. It is delivered on `ref_rdata` or `host_rdata` with a one-clock valid pulse on the following clock. At most one valid pulses at a time.
- R6: When `ref_req` is high and a slot is free, `ref_ack` is 1 and the refresh fetch takes the slot, even if a host access is pending. The cycle then reads from `ref_addr`.
- R7: A host request (`host_wr` or `host_rd`) is accepted on a clock where `host_busy` is 0. `host_busy` is 1 from the next clock until the host's memory cycle has finished.
- R8: A host request presented while `host_busy` is 1 is ignored: no memory cycle is run for it and memory is not changed.
- R9: The full 16-bit address range is reachable, including 0x0000 and 0xFFFF, for both sources.
- R10: `host_rdata` keeps the last host read byte until the next host read completes. Refresh fetches and host writes do not disturb it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_req | input | 1 | Refresh fetch request |
| ref_addr | input | 16 | Refresh fetch address |
| ref_ack | output | 1 | Refresh request taken on this clock edge |
| ref_rdata | output | 8 | Refresh read data |
| ref_rvalid | output | 1 | One-clock pulse, refresh data valid |
| host_wr | input | 1 | Host write request |
| host_rd | input | 1 | Host read request |
| host_addr | input | 16 | Host access address |
| host_wdata | input | 8 | Host write byte |
| host_busy | output | 1 | Host access pending or in progress |
| host_rdata | output | 8 | Host read return register |
| host_rvalid | output | 1 | One-clock pulse, host read data valid |
| mem_addr | output | 16 | SRAM address |
| mem_ce_n | output | 1 | SRAM chip enable, active low |
| mem_rw | output | 1 | SRAM direction, 1 read, 0 write |
| mem_dq_out | output | 8 | SRAM write data to pad |
| mem_dq_oe | output | 1 | Pad output enable for write data |
| mem_dq_in | input | 8 | SRAM read data from pad |

## Verification
The properties assume that the refresh requester keeps `ref_req` and `ref_addr` steady until it sees `ref_ack`. They also assume the host raises at most one of `host_wr` and `host_rd` per clock, and that the SRAM presents read data before the last low clock of a read. The bench drives all inputs on the falling edge. Its refresh task holds each address until it observes the acknowledge. Its SRAM model registers read data one clock after the enable falls. One deliberate request made while busy is the only stimulus that steps outside the handshake, and it exists to show that such a request is dropped.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 8;
    localparam int PHASE_W = 2;

    typedef enum logic {
        SRC_REF  = 1'b0,
        SRC_HOST = 1'b1
    } src_e;

    typedef enum logic [PHASE_W-1:0] {
        PH_SETUP = 2'd0,
        PH_LOW1  = 2'd1,
        PH_LOW2  = 2'd2
    } phase_e;

    typedef struct packed {
        src_e              src;
        logic              is_rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } mem_cmd_t;

    localparam mem_cmd_t CMD_IDLE = '{src: SRC_REF, is_rd: 1'b1, addr: '0, wdata: '0};

    function automatic phase_e next_phase(input phase_e p);
        case (p)
            PH_SETUP: return PH_LOW1;
            PH_LOW1:  return PH_LOW2;
            default:  return PH_SETUP;
        endcase
    endfunction

    function automatic logic enable_low(input logic active, input phase_e p);
        return active && (p != PH_SETUP);
    endfunction

endpackage

// File: rtl/vseq_host_buf.sv
module vseq_host_buf
    import vseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              take,
    input  logic              done,
    output logic              pend_valid,
    output mem_cmd_t          pend_cmd,
    output logic              busy
);

    logic accept;

    assign accept = (host_wr || host_rd) && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_valid <= 1'b0;
            busy       <= 1'b0;
            pend_cmd   <= CMD_IDLE;
        end else if (accept) begin
            pend_valid <= 1'b1;
            busy       <= 1'b1;
            pend_cmd   <= '{src: SRC_HOST, is_rd: !host_wr,
                            addr: host_addr, wdata: host_wdata};
        end else begin
            if (take) pend_valid <= 1'b0;
            if (done) busy       <= 1'b0;
        end
    end

endmodule

// File: rtl/vseq_arbiter.sv
module vseq_arbiter
    import vseq_pkg::*;
(
    input  logic              slot_free,
    input  logic              ref_req,
    input  logic [ADDR_W-1:0] ref_addr,
    input  logic              pend_valid,
    input  mem_cmd_t          pend_cmd,
    output logic              grant_ref,
    output logic              grant_host,
    output logic              load,
    output mem_cmd_t          load_cmd
);

    always_comb begin
        grant_ref  = slot_free && ref_req;
        grant_host = slot_free && !ref_req && pend_valid;
        load       = grant_ref || grant_host;
        if (grant_ref)
            load_cmd = '{src: SRC_REF, is_rd: 1'b1, addr: ref_addr, wdata: '0};
        else
            load_cmd = pend_cmd;
    end

endmodule

// File: rtl/vseq_cycle.sv
module vseq_cycle
    import vseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  mem_cmd_t          load_cmd,
    input  logic [DATA_W-1:0] dq_in,
    output logic              slot_free,
    output logic              done_host,
    output logic              active,
    output phase_e            phase,
    output mem_cmd_t          cur,
    output logic [DATA_W-1:0] ref_rdata,
    output logic              ref_rvalid,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid
);

    logic last_clk;

    assign last_clk  = active && (phase == PH_LOW2);
    assign slot_free = !active || (phase == PH_LOW2);
    assign done_host = last_clk && (cur.src == SRC_HOST);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            phase  <= PH_SETUP;
            cur    <= CMD_IDLE;
        end else if (load) begin
            active <= 1'b1;
            phase  <= PH_SETUP;
            cur    <= load_cmd;
        end else if (last_clk) begin
            active <= 1'b0;
            phase  <= PH_SETUP;
        end else if (active) begin
            phase  <= next_phase(phase);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_rdata   <= '0;
            ref_rvalid  <= 1'b0;
            host_rdata  <= '0;
            host_rvalid <= 1'b0;
        end else begin
            ref_rvalid  <= 1'b0;
            host_rvalid <= 1'b0;
            if (last_clk && cur.is_rd) begin
                if (cur.src == SRC_REF) begin
                    ref_rdata  <= dq_in;
                    ref_rvalid <= 1'b1;
                end else begin
                    host_rdata  <= dq_in;
                    host_rvalid <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/vram_seq.sv
module vram_seq
    import vseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_req,
    input  logic [ADDR_W-1:0] ref_addr,
    output logic              ref_ack,
    output logic [DATA_W-1:0] ref_rdata,
    output logic              ref_rvalid,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_busy,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_rw,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    logic     slot_free, done_host, active;
    logic     grant_ref, grant_host, load, pend_valid;
    phase_e   phase;
    mem_cmd_t cur, load_cmd, pend_cmd;

    vseq_host_buf u_hbuf (
        .clk        (clk),
        .rst        (rst),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .take       (grant_host),
        .done       (done_host),
        .pend_valid (pend_valid),
        .pend_cmd   (pend_cmd),
        .busy       (host_busy)
    );

    vseq_arbiter u_arb (
        .slot_free  (slot_free),
        .ref_req    (ref_req),
        .ref_addr   (ref_addr),
        .pend_valid (pend_valid),
        .pend_cmd   (pend_cmd),
        .grant_ref  (grant_ref),
        .grant_host (grant_host),
        .load       (load),
        .load_cmd   (load_cmd)
    );

    vseq_cycle u_cyc (
        .clk         (clk),
        .rst         (rst),
        .load        (load),
        .load_cmd    (load_cmd),
        .dq_in       (mem_dq_in),
        .slot_free   (slot_free),
        .done_host   (done_host),
        .active      (active),
        .phase       (phase),
        .cur         (cur),
        .ref_rdata   (ref_rdata),
        .ref_rvalid  (ref_rvalid),
        .host_rdata  (host_rdata),
        .host_rvalid (host_rvalid)
    );

    assign ref_ack    = grant_ref;
    assign mem_addr   = cur.addr;
    assign mem_ce_n   = !enable_low(active, phase);
    assign mem_rw     = active ? cur.is_rd : 1'b1;
    assign mem_dq_out = cur.wdata;
    assign mem_dq_oe  = active && !cur.is_rd;

endmodule

// File: rtl/vram_seq_chk.sv
module vram_seq_chk
    import vseq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ref_req,
    input logic [ADDR_W-1:0] ref_addr,
    input logic              ref_ack,
    input logic              ref_rvalid,
    input logic              host_wr,
    input logic              host_rd,
    input logic              host_busy,
    input logic              host_rvalid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_rw,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe
);

    assert_ce_low_two_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_ce_n) |=> !mem_ce_n);

    assert_ce_rise_R2: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && $past(!mem_ce_n)) |=> mem_ce_n);

    assert_rw_stable_R3: assert property (@(posedge clk) disable iff (rst)
        !mem_ce_n |-> $stable(mem_rw));

    assert_wdata_driven_R4: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && !mem_rw) |-> mem_dq_oe);

    assert_wdata_hold_R4: assert property (@(posedge clk) disable iff (rst)
        ($fell(mem_ce_n) && !mem_rw) |=> $stable(mem_dq_out));

    assert_one_valid_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ref_rvalid, host_rvalid}));

    assert_host_rvalid_after_read_R5: assert property (@(posedge clk) disable iff (rst)
        host_rvalid |-> $past(!mem_ce_n && mem_rw));

    assert_ref_slot_R6: assert property (@(posedge clk) disable iff (rst)
        (ref_req && ref_ack) |=> (mem_ce_n && mem_rw && mem_addr == $past(ref_addr)));

    assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (rst)
        ((host_wr || host_rd) && !host_busy) |=> host_busy);

endmodule

bind vram_seq vram_seq_chk u_chk (.*);

// File: tb/sim_vram_seq.sv
`timescale 1ns/1ps
module sim_vram_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_req = 1'b0;
    logic [15:0] ref_addr = '0;
    logic        ref_ack;
    logic [7:0]  ref_rdata;
    logic        ref_rvalid;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [15:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_busy;
    logic [7:0]  host_rdata;
    logic        host_rvalid;
    logic [15:0] mem_addr;
    logic        mem_ce_n;
    logic        mem_rw;
    logic [7:0]  mem_dq_out;
    logic        mem_dq_oe;
    logic [7:0]  mem_dq_in = '0;

    int checks = 0;
    int errors = 0;
    int wcycles = 0;

    logic [7:0] sram   [logic [15:0]];
    logic [7:0] shadow [logic [15:0]];
    logic [7:0] ref_q  [$];
    logic [7:0] host_q [$];

    always #4 clk = ~clk;

    vram_seq u0 (.*);

    // SRAM model: writes on low phase, read data registered one clock after enable falls
    always @(posedge clk) begin
        if (!mem_ce_n && !mem_rw && mem_dq_oe) sram[mem_addr] = mem_dq_out;
        if (!mem_ce_n && mem_rw)
            mem_dq_in <= sram.exists(mem_addr) ? sram[mem_addr] : 8'h00;
    end

    function automatic logic [7:0] sget(input logic [15:0] a);
        return shadow.exists(a) ? shadow[a] : 8'h00;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: scoreboard pops plus waveform checks
    logic prev_ce = 1'b1;
    logic fall_rw = 1'b1;
    int   lowrun  = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (ref_rvalid) begin
                if (ref_q.size() == 0) chk(0, "R5 unexpected ref data", ref_rdata, 0);
                else begin
                    logic [7:0] e;
                    e = ref_q.pop_front();
                    chk(ref_rdata == e, "R5/R9 ref read data", ref_rdata, e);
                end
            end
            if (host_rvalid) begin
                if (host_q.size() == 0) chk(0, "R5 unexpected host data", host_rdata, 0);
                else begin
                    logic [7:0] e;
                    e = host_q.pop_front();
                    chk(host_rdata == e, "R5/R9 host read data", host_rdata, e);
                end
            end
            if (prev_ce && !mem_ce_n) begin
                fall_rw = mem_rw;
                lowrun  = 1;
                if (!mem_rw) wcycles++;
            end else if (!mem_ce_n) begin
                lowrun++;
                chk(mem_rw == fall_rw, "R3 rw stable in low phase", mem_rw, fall_rw);
            end
            if (!mem_ce_n && !mem_rw)
                chk(mem_dq_oe == 1'b1, "R4 write data driven", mem_dq_oe, 1);
            if (!prev_ce && mem_ce_n)
                chk(lowrun == 2, "R2 enable low two clocks", lowrun, 2);
            prev_ce = mem_ce_n;
        end
    end

    task automatic host_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        while (host_busy) @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        shadow[a] = d;
        @(negedge clk);
        host_wr = 1'b0;
        chk(host_busy == 1'b1, "R7 busy after write accept", host_busy, 1);
    endtask

    task automatic host_read(input logic [15:0] a);
        @(negedge clk);
        while (host_busy) @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        host_q.push_back(sget(a));
        @(negedge clk);
        host_rd = 1'b0;
        chk(host_busy == 1'b1, "R7 busy after read accept", host_busy, 1);
    endtask

    task automatic ref_burst(input logic [15:0] base, input int n);
        @(negedge clk);
        ref_req = 1'b1;
        for (int i = 0; i < n; i++) begin
            ref_addr = base + 16'(i);
            #1;
            while (!ref_ack) begin
                @(negedge clk);
                #1;
            end
            ref_q.push_back(sget(ref_addr));
            @(negedge clk);
        end
        ref_req = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (2) @(negedge clk);
        while (host_busy || ref_q.size() != 0 || host_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int w0;
        logic [7:0] kept;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state while reset held
        chk(mem_ce_n == 1'b1, "R1 ce_n in reset", mem_ce_n, 1);
        chk(mem_rw == 1'b1, "R1 rw in reset", mem_rw, 1);
        chk(mem_dq_oe == 1'b0, "R1 oe in reset", mem_dq_oe, 0);
        chk(host_busy == 1'b0, "R1 busy in reset", host_busy, 0);
        chk(!ref_rvalid && !host_rvalid, "R1 valids in reset", {ref_rvalid, host_rvalid}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(mem_ce_n == 1'b1 && mem_rw == 1'b1, "R1 idle after reset", {mem_ce_n, mem_rw}, 3);

        // basic write and read back
        host_write(16'h1234, 8'h5A);
        host_write(16'h1235, 8'hC3);
        host_read(16'h1234);
        host_read(16'h1235);
        wait_idle();
        chk(host_busy == 1'b0, "R7 busy clears when done", host_busy, 0);

        // R9 address extremes
        host_write(16'h0000, 8'hA5);
        host_write(16'hFFFF, 8'h96);
        ref_burst(16'hFFFF, 2);   // 0xFFFF then wraps to 0x0000
        host_read(16'hFFFF);
        host_read(16'h0000);
        wait_idle();

        // refresh stream of several addresses, mixed with gaps
        for (int i = 0; i < 6; i++) host_write(16'h4000 + 16'(i), 8'(8'h10 * i + 3));
        ref_burst(16'h4000, 6);
        ref_burst(16'h1234, 2);
        wait_idle();

        // R6 refresh priority over a pending host write
        w0 = wcycles;
        fork
            begin
                @(negedge clk);
                host_wr = 1'b1; host_addr = 16'h2222; host_wdata = 8'h3C;
                shadow[16'h2222] = 8'h3C;
                @(negedge clk);
                host_wr = 1'b0;
            end
            ref_burst(16'h4000, 4);
            begin
                @(negedge clk);
                @(negedge clk);
                while (ref_req) begin
                    chk(wcycles == w0, "R6 host write held behind refresh", wcycles, w0);
                    chk(host_busy == 1'b1, "R6 host busy while refresh holds slots", host_busy, 1);
                    @(negedge clk);
                end
            end
        join
        wait_idle();
        chk(wcycles == w0 + 1, "R6 host write done after refresh", wcycles, w0 + 1);
        host_read(16'h2222);
        wait_idle();

        // R8 request while busy is dropped
        host_write(16'h0777, 8'h11);
        wait_idle();
        w0 = wcycles;
        host_write(16'h0888, 8'h22);
        chk(host_busy == 1'b1, "R8 busy before extra request", host_busy, 1);
        host_wr = 1'b1; host_addr = 16'h0777; host_wdata = 8'hEE;
        @(negedge clk);
        host_wr = 1'b0;
        wait_idle();
        chk(wcycles == w0 + 1, "R8 no cycle for dropped write", wcycles, w0 + 1);
        host_read(16'h0777);
        wait_idle();

        // R10 return register held across other traffic
        host_read(16'h1235);
        wait_idle();
        kept = host_rdata;
        chk(kept == 8'hC3, "R10 host read value", kept, 8'hC3);
        host_write(16'h5000, 8'h77);
        ref_burst(16'h4000, 3);
        wait_idle();
        chk(host_rdata == kept, "R10 host_rdata held", host_rdata, kept);

        chk(ref_q.size() == 0 && host_q.size() == 0, "R5 all reads returned",
            ref_q.size() + host_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule